// File: doc/BRIEF.md
# System Register Access Trap Router

This block decides whether an instruction that moves a value to or from a system register has to raise a trap, and if so which privilege level receives it. The access is described by its current exception level, a register-class code, the syndrome immediate carried by the instruction, and the processor's security state. The block also reads the feature-present flags and the trap-control fields that govern floating-point and SIMD state. It answers one clock edge after the request is presented, with a single-cycle pulse that carries the target level, the exception class and a 25-bit syndrome immediate.

Three checks are evaluated side by side and combined by a fixed priority. The supervisor check runs first, the hypervisor check second and the monitor check last, and the first check that fires decides the result. A floating-point or SIMD register access reports the FP/SIMD class with a fixed immediate. Any other trapped access reports the generic trapped-move class and carries the instruction's own immediate. Trap conditions for non-FP registers are computed by the surrounding register decoder and arrive here as one request bit per upper level.

The sequencing is a two-state machine. ST_IDLE is the resting state, and in it all outputs are quiet. A valid request that causes a trap takes the transition T_FIRE from ST_IDLE or from ST_TRAP into ST_TRAP, which presents the trap for exactly one cycle. A cycle with no trapping request takes T_DONE from ST_TRAP, or T_STAY from ST_IDLE, back to ST_IDLE. Reset forces ST_IDLE.

Top module: `sysreg_trap_router`

## Requirements
- R1: A synchronous active-high reset drives trap_valid low and trap_target to 0 (no target) at the first clock edge at which reset is high.
- R2: The result for a request shows on the outputs at the clock edge that follows the cycle in which req_valid was high. trap_valid is high only in the cycle after such a request, and a cycle with req_valid low produces no trap.
- R3: For FP register classes (req_class 1, 2 or 3), the supervisor check fires in two cases: at level 0 when fp_enable is not 3, and at level 1 when fp_enable bit 0 is 0. It never fires at levels 2 or 3.
- R4: For FP register classes, the hypervisor check fires when hyp_fp_trap is 1, secure_state is 0 and the level is not 2. For req_class 0 it fires when hyp_gen_trap is 1 under the same security and level conditions.
- R5: For FP register classes, the monitor check fires when mon_fp_trap is 1. For req_class 0 it fires when mon_gen_trap is 1.
- R6: Priority is supervisor over hypervisor over monitor. trap_target is 1 for supervisor, 2 for hypervisor and 3 for monitor.
- R7: The hypervisor check is enabled only when virt_present is 1 and the level is at most 2. The monitor check is enabled only when sec_present is 1.
- R8: Any trap on an FP register class reports trap_class 6'h07 and trap_imm 25'h1E00000, whatever req_imm holds.
- R9: A trap on req_class 0 reports trap_class 6'h18 and trap_imm equal to the req_imm of the request.
- R10: When no check fires, trap_valid is 0 and trap_target, trap_class and trap_imm are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_level | input | 2 | Current exception level, 0 to 3 |
| req_class | input | 2 | 0 generic, 1 FP control, 2 FP status, 3 FP 32-bit exception register |
| req_imm | input | IMM_W (25) | Syndrome immediate supplied by the instruction |
| secure_state | input | 1 | 1 when the processor is in secure state |
| virt_present | input | 1 | Virtualization support implemented |
| sec_present | input | 1 | Security support implemented |
| fp_enable | input | 2 | FP enable field of the level-1 access control register |
| hyp_fp_trap | input | 1 | Level-2 trap-FP control bit |
| mon_fp_trap | input | 1 | Level-3 trap-FP control bit |
| hyp_gen_trap | input | 1 | Decoder request: trap this non-FP access to level 2 |
| mon_gen_trap | input | 1 | Decoder request: trap this non-FP access to level 3 |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_target | output | 2 | 0 none, 1 supervisor, 2 hypervisor, 3 monitor |
| trap_class | output | CLASS_W (6) | Exception class code |
| trap_imm | output | IMM_W (25) | Syndrome immediate |

## Verification
The bench uses the default parameters: a 25-bit immediate and 6-bit class codes, with 6'h07 and 6'h18 as the class values. With these widths the fixed FP immediate sits at its real bit positions, and random immediates cover the full field, so an echo of the wrong bits would be caught. Because the level and class inputs are only two bits each, the random stream covers every combination of level, class, security state and feature flags many times over. Directed cases add the priority collisions and the gating cases at level 2.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SUP  = 2'd1,
        TGT_HYP  = 2'd2,
        TGT_MON  = 2'd3
    } trap_tgt_e;

    typedef enum logic [1:0] {
        RC_GENERIC  = 2'd0,
        RC_FP_CTRL  = 2'd1,
        RC_FP_STAT  = 2'd2,
        RC_FP_EXC32 = 2'd3
    } reg_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } route_state_e;

    localparam int NUM_STAGES = 3;

endpackage

// File: rtl/level_trap_check.sv
module level_trap_check #(
    parameter int MAX_LEVEL   = 1,
    parameter bit NONSEC_ONLY = 1'b0,
    parameter bit SUP_FP_RULE = 1'b0
) (
    input  logic [1:0] level,
    input  logic       is_fp,
    input  logic       secure_state,
    input  logic       feature_ok,
    input  logic [1:0] fp_enable,
    input  logic       fp_trap,
    input  logic       gen_trap,
    output logic       fire
);
    localparam logic [1:0] LVL_LIMIT = 2'(MAX_LEVEL);

    logic in_range;
    logic gate_ok;
    logic sup_rule;
    logic fp_hit;

    always_comb begin
        in_range = (level <= LVL_LIMIT);
        gate_ok  = NONSEC_ONLY ? (!secure_state && (level != 2'd2)) : 1'b1;
        sup_rule = ((level == 2'd0) && (fp_enable != 2'd3)) ||
                   ((level == 2'd1) && !fp_enable[0]);
        fp_hit   = SUP_FP_RULE ? sup_rule : fp_trap;
        fire     = feature_ok && in_range && gate_ok && (is_fp ? fp_hit : gen_trap);
    end

endmodule

// File: rtl/sysreg_trap_router.sv
module sysreg_trap_router
    import trap_route_pkg::*;
#(
    parameter int              IMM_W     = 25,
    parameter int              CLASS_W   = 6,
    parameter logic [CLASS_W-1:0] FP_CLASS  = 6'h07,
    parameter logic [CLASS_W-1:0] GEN_CLASS = 6'h18,
    parameter logic [IMM_W-1:0]   FP_IMM    = 25'h1E00000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_level,
    input  logic [1:0]         req_class,
    input  logic [IMM_W-1:0]   req_imm,
    input  logic               secure_state,
    input  logic               virt_present,
    input  logic               sec_present,
    input  logic [1:0]         fp_enable,
    input  logic               hyp_fp_trap,
    input  logic               mon_fp_trap,
    input  logic               hyp_gen_trap,
    input  logic               mon_gen_trap,
    output logic               trap_valid,
    output logic [1:0]         trap_target,
    output logic [CLASS_W-1:0] trap_class,
    output logic [IMM_W-1:0]   trap_imm
);
    logic [NUM_STAGES-1:0] stage_fire;
    logic [NUM_STAGES-1:0] stage_feat;
    logic [NUM_STAGES-1:0] stage_fp_trap;
    logic [NUM_STAGES-1:0] stage_gen_trap;
    logic                  is_fp;

    assign is_fp          = (reg_class_e'(req_class) != RC_GENERIC);
    assign stage_feat     = {sec_present, virt_present, 1'b1};
    assign stage_fp_trap  = {mon_fp_trap, hyp_fp_trap, 1'b0};
    assign stage_gen_trap = {mon_gen_trap, hyp_gen_trap, 1'b0};

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        localparam int MAXL   = g + 1;
        localparam bit NONSEC = (g == 1);
        localparam bit SUPFP  = (g == 0);
        level_trap_check #(
            .MAX_LEVEL  (MAXL),
            .NONSEC_ONLY(NONSEC),
            .SUP_FP_RULE(SUPFP)
        ) u_check (
            .level       (req_level),
            .is_fp       (is_fp),
            .secure_state(secure_state),
            .feature_ok  (stage_feat[g]),
            .fp_enable   (fp_enable),
            .fp_trap     (stage_fp_trap[g]),
            .gen_trap    (stage_gen_trap[g]),
            .fire        (stage_fire[g])
        );
    end

    trap_tgt_e          pick_tgt;
    logic [CLASS_W-1:0] pick_class;
    logic [IMM_W-1:0]   pick_imm;
    logic               take;

    always_comb begin
        if (stage_fire[0])      pick_tgt = TGT_SUP;
        else if (stage_fire[1]) pick_tgt = TGT_HYP;
        else if (stage_fire[2]) pick_tgt = TGT_MON;
        else                    pick_tgt = TGT_NONE;
        pick_class = is_fp ? FP_CLASS : GEN_CLASS;
        pick_imm   = is_fp ? FP_IMM   : req_imm;
        take       = req_valid && (pick_tgt != TGT_NONE);
    end

    route_state_e state, state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = take ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_nx = take ? ST_TRAP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    logic [1:0]         tgt_q;
    logic [CLASS_W-1:0] class_q;
    logic [IMM_W-1:0]   imm_q;

    always_ff @(posedge clk) begin
        if (rst || !take) begin
            tgt_q   <= TGT_NONE;
            class_q <= '0;
            imm_q   <= '0;
        end else begin
            tgt_q   <= pick_tgt;
            class_q <= pick_class;
            imm_q   <= pick_imm;
        end
    end

    assign trap_valid  = (state == ST_TRAP);
    assign trap_target = tgt_q;
    assign trap_class  = class_q;
    assign trap_imm    = imm_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!trap_valid && trap_target == 2'd0));

    assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> $past(req_valid));

    assert_sup_level_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_target == 2'd1) |-> ($past(req_level) <= 2'd1));

    assert_hyp_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_target == 2'd2) |-> ($past(virt_present) && $past(req_level) <= 2'd2));

    assert_mon_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_target == 2'd3) |-> $past(sec_present));

    assert_fp_syndrome_R8: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && $past(req_class) != 2'd0) |-> (trap_class == FP_CLASS && trap_imm == FP_IMM));

    assert_gen_syndrome_R9: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && $past(req_class) == 2'd0) |-> (trap_class == GEN_CLASS && trap_imm == $past(req_imm)));

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |-> (trap_target == 2'd0 && trap_class == '0 && trap_imm == '0));

endmodule

// File: tb/sysreg_trap_router_tb.sv
`timescale 1ns/1ps
module sysreg_trap_router_tb;
    localparam int IMM_W   = 25;
    localparam int CLASS_W = 6;

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid;
    logic [1:0]         req_level;
    logic [1:0]         req_class;
    logic [IMM_W-1:0]   req_imm;
    logic               secure_state, virt_present, sec_present;
    logic [1:0]         fp_enable;
    logic               hyp_fp_trap, mon_fp_trap, hyp_gen_trap, mon_gen_trap;
    logic               trap_valid;
    logic [1:0]         trap_target;
    logic [CLASS_W-1:0] trap_class;
    logic [IMM_W-1:0]   trap_imm;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sysreg_trap_router u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .req_class(req_class), .req_imm(req_imm), .secure_state(secure_state),
        .virt_present(virt_present), .sec_present(sec_present), .fp_enable(fp_enable),
        .hyp_fp_trap(hyp_fp_trap), .mon_fp_trap(mon_fp_trap),
        .hyp_gen_trap(hyp_gen_trap), .mon_gen_trap(mon_gen_trap),
        .trap_valid(trap_valid), .trap_target(trap_target),
        .trap_class(trap_class), .trap_imm(trap_imm)
    );

    logic               exp_valid;
    logic [1:0]         exp_tgt;
    logic [CLASS_W-1:0] exp_class;
    logic [IMM_W-1:0]   exp_imm;

    function automatic logic [1:0] model_target();
        logic fp;
        logic sup, hyp, mon;
        fp  = (req_class != 2'd0);
        sup = fp && (((req_level == 2'd0) && (fp_enable != 2'd3)) ||
                     ((req_level == 2'd1) && !fp_enable[0]));
        hyp = virt_present && (req_level <= 2'd2) && !secure_state && (req_level != 2'd2) &&
              (fp ? hyp_fp_trap : hyp_gen_trap);
        mon = sec_present && (fp ? mon_fp_trap : mon_gen_trap);
        if (!req_valid) return 2'd0;
        if (sup) return 2'd1;
        if (hyp) return 2'd2;
        if (mon) return 2'd3;
        return 2'd0;
    endfunction

    task automatic compute_expected();
        exp_tgt   = model_target();
        exp_valid = (exp_tgt != 2'd0);
        if (!exp_valid) begin
            exp_class = '0;
            exp_imm   = '0;
        end else if (req_class != 2'd0) begin
            exp_class = 6'h07;
            exp_imm   = 25'h1E00000;
        end else begin
            exp_class = 6'h18;
            exp_imm   = req_imm;
        end
    endtask

    task automatic check_out(string tag);
        tests_run++;
        if (trap_valid !== exp_valid || trap_target !== exp_tgt ||
            trap_class !== exp_class || trap_imm !== exp_imm) begin
            tests_failed++;
            $display("FAIL %s: actual v=%0b tgt=%0d cls=%h imm=%h expected v=%0b tgt=%0d cls=%h imm=%h",
                     tag, trap_valid, trap_target, trap_class, trap_imm,
                     exp_valid, exp_tgt, exp_class, exp_imm);
        end
    endtask

    // inputs are set just after a negedge; result checked at the next negedge
    task automatic step(string tag);
        compute_expected();
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic set_req(input logic v, input logic [1:0] lvl, input logic [1:0] cls,
                           input logic [IMM_W-1:0] imm, input logic sec, input logic vp,
                           input logic sp, input logic [1:0] fpe, input logic hf,
                           input logic mf, input logic hg, input logic mg);
        req_valid = v; req_level = lvl; req_class = cls; req_imm = imm;
        secure_state = sec; virt_present = vp; sec_present = sp; fp_enable = fpe;
        hyp_fp_trap = hf; mon_fp_trap = mf; hyp_gen_trap = hg; mon_gen_trap = mg;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        set_req(1'b1, 2'd0, 2'd1, 25'h0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk); @(negedge clk);
        tests_run++;
        if (trap_valid !== 1'b0 || trap_target !== 2'd0) begin
            tests_failed++;
            $display("FAIL R1: actual v=%0b tgt=%0d expected v=0 tgt=0", trap_valid, trap_target);
        end
        rst = 1'b0;

        // R3 R8: level 0, enable field 1 -> supervisor, FP syndrome despite req_imm
        set_req(1'b1, 2'd0, 2'd1, 25'h0ABCDEF, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R3 R8 level0 fpen1");
        // R3: level 0, enable 3 -> no supervisor trap, nothing else set
        set_req(1'b1, 2'd0, 2'd2, 25'h1, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R3 R10 level0 fpen3");
        // R3: level 1, enable 2 (bit0 clear) -> supervisor
        set_req(1'b1, 2'd1, 2'd3, 25'h1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R3 level1 fpen2");
        // R4: level 1, enable 1 -> hyp trap bit non-secure
        set_req(1'b1, 2'd1, 2'd1, 25'h1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R4 R6 hyp over mon");
        // R4 R5: secure state skips hyp -> monitor
        set_req(1'b1, 2'd1, 2'd1, 25'h1, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R4 R5 secure to mon");
        // R4: level 2 skips hyp -> monitor
        set_req(1'b1, 2'd2, 2'd2, 25'h1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R4 level2 to mon");
        // R6: supervisor beats hyp and mon
        set_req(1'b1, 2'd0, 2'd1, 25'h1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R6 sup first");
        // R7: virtualization absent -> monitor
        set_req(1'b1, 2'd0, 2'd0, 25'h1234567, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R7 R9 no virt");
        // R7: security absent -> none
        set_req(1'b1, 2'd3, 2'd1, 25'h1, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R7 R10 no sec");
        // R9: generic hyp trap echoes immediate
        set_req(1'b1, 2'd1, 2'd0, 25'h1FFFFFF, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R9 generic hyp");
        // R5: level 3 monitor FP
        set_req(1'b1, 2'd3, 2'd3, 25'h5, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R5 level3 mon");
        // R2: no request with trapping inputs -> quiet
        set_req(1'b0, 2'd0, 2'd1, 25'h5, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R2 no request");
        // R2: back-to-back trapping requests, each reported next cycle
        set_req(1'b1, 2'd0, 2'd0, 25'h00000AA, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R2 b2b first");
        set_req(1'b1, 2'd0, 2'd0, 25'h0000055, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        step("R2 b2b second");

        for (int i = 0; i < 4000; i++) begin
            set_req(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 25'($urandom),
                    1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0, 2'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            step("R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        // R1: reset in mid-traffic clears outputs
        set_req(1'b1, 2'd0, 2'd1, 25'h0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        tests_run++;
        if (trap_valid !== 1'b0 || trap_target !== 2'd0) begin
            tests_failed++;
            $display("FAIL R1 mid: actual v=%0b tgt=%0d expected v=0 tgt=0", trap_valid, trap_target);
        end
        rst = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule